// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block is the control engine that carries out a protected-mode task switch. A jump, call, software interrupt or interrupt-return presents a request together with the privilege levels in play and the flags of the target task-state descriptor. The sequencer first screens the request. It then walks a fixed series of memory phases: it clears the old busy mark, sets the new busy mark, saves the outgoing state, loads the general registers, loads the local table, loads the segments and loads the instruction pointer.

Each memory phase is a request/acknowledge handshake. The surrounding memory engine performs the transfer and signals on the acknowledge whether the validation tied to that phase failed. The sequencer finishes with either a one-cycle completion pulse or a one-cycle fault pulse. The fault pulse carries an exception number and a 16-bit error selector.

The states are named as follows:
- `ST_IDLE` waits for start.
- `ST_CHECK` screens privilege, presence and busy.
- `ST_CLR_OLD` and `ST_SET_BUSY` update the busy marks.
- `ST_SAVE_OLD` and `ST_LOAD_REGS` move the dynamic state.
- `ST_FLAGS` raises the flag updates.
- `ST_LOAD_LDT`, `ST_LOAD_SEG` and `ST_LOAD_IP` fetch and validate.
- `ST_DONE` and `ST_FAULT` report the outcome.

The transitions are:
- IDLE goes to CHECK on an accepted start.
- CHECK goes to FAULT on a failed check, to SET_BUSY for call or interrupt, and otherwise to CLR_OLD.
- Each memory state advances on acknowledge.
- Each of the three load-validate states goes to FAULT on a flagged acknowledge.
- DONE and FAULT return to IDLE.

Top module: `task_switch_seq`

## Requirements
- R1: After reset the block is idle: `active`, `mem_req`, `done`, `fault`, `set_ts` and `set_nt` are all 0, and `mem_req` stays 0 whenever the block is idle.
- R2: For request kinds jump (0), call (1) and interrupt (2), a target privilege `dpl` numerically below `cpl` or below `rpl` raises a fault with vector 13. The error selector is `gate_sel` when `via_gate` is 1 and `tss_sel` otherwise. No memory phase is issued.
- R3: For interrupt-return (kind 3) the privilege test is skipped. An interrupt-return start with `nt_flag` 0 is ignored: the block stays idle and issues no phase, done or fault.
- R4: When the privilege test passes, a clear `present` raises vector 11 and a set `desc_busy` raises vector 13, both with error selector `tss_sel`. The order of precedence is privilege, then present, then busy.
- R5: On a valid request, jump and interrupt-return issue phases `mem_op` 1,2,3,4,5,6,7 in that order, and call and interrupt issue 2,3,4,5,6,7. The codes are: 1 clear old busy, 2 set new busy, 3 save old state, 4 load registers, 5 load local table, 6 load segments, 7 load instruction pointer.
- R6: For one cycle between phase 4 and phase 5, `set_ts` is 1. In that same cycle, `set_nt` is 1 exactly for call and interrupt, and `set_nt` is never 1 without `set_ts`.
- R7: A phase holds `mem_req` high with a stable `mem_op` until `mem_ack` is seen, and advances only on `mem_ack`.
- R8: When `mem_bad` is 1 with the acknowledge, phase 5 or 6 faults with vector 10 and selector `tss_sel`, and phase 7 faults with vector 13 and selector 0. No later phase is issued.
- R9: Success gives exactly one `done` pulse one cycle after the phase 7 acknowledge. `done` and `fault` never coincide, and `start` is ignored while `active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a switch (sampled when idle) |
| kind | input | 2 | 0 jump, 1 call, 2 interrupt, 3 interrupt-return |
| via_gate | input | 1 | Switch goes through a task gate |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requester privilege level |
| dpl | input | 2 | Gate or descriptor privilege level |
| present | input | 1 | Target descriptor present |
| desc_busy | input | 1 | Target descriptor already busy |
| nt_flag | input | 1 | Current nested-task flag |
| gate_sel | input | 16 | Gate selector |
| tss_sel | input | 16 | Target task-state selector |
| mem_ack | input | 1 | Memory phase complete |
| mem_bad | input | 1 | Validation failed for the phase being acknowledged |
| active | output | 1 | Switch in progress |
| mem_req | output | 1 | Memory phase request |
| mem_op | output | 4 | Phase code |
| set_ts | output | 1 | Set task-switched flag pulse |
| set_nt | output | 1 | Set nested-task flag in new task pulse |
| done | output | 1 | Switch completed pulse |
| fault | output | 1 | Switch aborted pulse |
| fault_vec | output | 8 | Exception number, valid with fault |
| fault_err | output | 16 | Error selector, valid with fault |

## Verification
The assertions assume that the memory engine raises `mem_ack` only while `mem_req` is high, and treats `mem_bad` as meaningful only on acknowledges of phases 5 to 7. They also assume that the request fields are stable in the cycle `start` is sampled. The stimulus keeps to these assumptions. It raises the acknowledge only after seeing a request, with a random wait of zero to three cycles. It drives `mem_bad` only on the single phase chosen to fail, and it changes the request fields only at falling edges before a fresh start. Extra starts are injected mid-switch, and an interrupt-return with a clear nested flag is sent, to exercise the ignore paths.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [1:0] {
        K_JMP  = 2'd0,
        K_CALL = 2'd1,
        K_INT  = 2'd2,
        K_IRET = 2'd3
    } req_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CLR_OLD,
        ST_SET_BUSY,
        ST_SAVE_OLD,
        ST_LOAD_REGS,
        ST_FLAGS,
        ST_LOAD_LDT,
        ST_LOAD_SEG,
        ST_LOAD_IP,
        ST_DONE,
        ST_FAULT
    } state_t;

    localparam logic [3:0] OP_NONE      = 4'd0;
    localparam logic [3:0] OP_CLR_OLD   = 4'd1;
    localparam logic [3:0] OP_SET_BUSY  = 4'd2;
    localparam logic [3:0] OP_SAVE_OLD  = 4'd3;
    localparam logic [3:0] OP_LOAD_REGS = 4'd4;
    localparam logic [3:0] OP_LOAD_LDT  = 4'd5;
    localparam logic [3:0] OP_LOAD_SEG  = 4'd6;
    localparam logic [3:0] OP_LOAD_IP   = 4'd7;

    localparam int VEC_BAD_TSS = 10;
    localparam int VEC_NOT_PRES = 11;
    localparam int VEC_PROT = 13;

endpackage

// File: rtl/tsw_entry_check.sv
module tsw_entry_check
    import tsw_pkg::*;
#(
    parameter int PL_W  = 2,
    parameter int SEL_W = 16,
    parameter int VEC_W = 8
) (
    input  req_kind_t        kind,
    input  logic             via_gate,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  rpl,
    input  logic [PL_W-1:0]  dpl,
    input  logic             present,
    input  logic             desc_busy,
    input  logic [SEL_W-1:0] gate_sel,
    input  logic [SEL_W-1:0] tss_sel,
    output logic             bad,
    output logic [VEC_W-1:0] vec,
    output logic [SEL_W-1:0] err
);
    logic priv_fail;

    // Interrupt-return skips the privilege screen entirely.
    assign priv_fail = (kind != K_IRET) && ((dpl < cpl) || (dpl < rpl));

    always_comb begin
        bad = 1'b1;
        vec = VEC_W'(VEC_PROT);
        err = tss_sel;
        if (priv_fail) begin
            err = via_gate ? gate_sel : tss_sel;
        end else if (!present) begin
            vec = VEC_W'(VEC_NOT_PRES);
        end else if (desc_busy) begin
            vec = VEC_W'(VEC_PROT);
        end else begin
            bad = 1'b0;
            vec = '0;
            err = '0;
        end
    end
endmodule

// File: rtl/tsw_op_encode.sv
module tsw_op_encode
    import tsw_pkg::*;
#(
    parameter int OP_W = 4
) (
    input  state_t          state,
    output logic            mem_req,
    output logic [OP_W-1:0] mem_op
);
    always_comb begin
        mem_req = 1'b1;
        unique case (state)
            ST_CLR_OLD:   mem_op = OP_W'(OP_CLR_OLD);
            ST_SET_BUSY:  mem_op = OP_W'(OP_SET_BUSY);
            ST_SAVE_OLD:  mem_op = OP_W'(OP_SAVE_OLD);
            ST_LOAD_REGS: mem_op = OP_W'(OP_LOAD_REGS);
            ST_LOAD_LDT:  mem_op = OP_W'(OP_LOAD_LDT);
            ST_LOAD_SEG:  mem_op = OP_W'(OP_LOAD_SEG);
            ST_LOAD_IP:   mem_op = OP_W'(OP_LOAD_IP);
            default: begin
                mem_req = 1'b0;
                mem_op  = OP_W'(OP_NONE);
            end
        endcase
    end
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
    import tsw_pkg::*;
#(
    parameter int PL_W  = 2,
    parameter int SEL_W = 16,
    parameter int VEC_W = 8,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       kind,
    input  logic             via_gate,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  rpl,
    input  logic [PL_W-1:0]  dpl,
    input  logic             present,
    input  logic             desc_busy,
    input  logic             nt_flag,
    input  logic [SEL_W-1:0] gate_sel,
    input  logic [SEL_W-1:0] tss_sel,
    input  logic             mem_ack,
    input  logic             mem_bad,
    output logic             active,
    output logic             mem_req,
    output logic [OP_W-1:0]  mem_op,
    output logic             set_ts,
    output logic             set_nt,
    output logic             done,
    output logic             fault,
    output logic [VEC_W-1:0] fault_vec,
    output logic [SEL_W-1:0] fault_err
);
    state_t           state, nxt;
    req_kind_t        k_q;
    logic             via_q, pres_q, busy_q;
    logic [PL_W-1:0]  cpl_q, rpl_q, dpl_q;
    logic [SEL_W-1:0] gsel_q, tsel_q;
    logic [VEC_W-1:0] vec_q;
    logic [SEL_W-1:0] err_q;
    logic             chk_bad;
    logic [VEC_W-1:0] chk_vec;
    logic [SEL_W-1:0] chk_err;
    logic             nested;
    logic             accept;
    logic             bad_ack;

    assign nested  = (k_q == K_CALL) || (k_q == K_INT);
    assign accept  = start && !(req_kind_t'(kind) == K_IRET && !nt_flag);
    assign bad_ack = mem_ack && mem_bad;

    tsw_entry_check #(.PL_W(PL_W), .SEL_W(SEL_W), .VEC_W(VEC_W)) u_chk (
        .kind(k_q), .via_gate(via_q), .cpl(cpl_q), .rpl(rpl_q), .dpl(dpl_q),
        .present(pres_q), .desc_busy(busy_q), .gate_sel(gsel_q), .tss_sel(tsel_q),
        .bad(chk_bad), .vec(chk_vec), .err(chk_err)
    );

    tsw_op_encode #(.OP_W(OP_W)) u_enc (
        .state(state), .mem_req(mem_req), .mem_op(mem_op)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request capture and fault record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q <= K_JMP; via_q <= 1'b0; pres_q <= 1'b0; busy_q <= 1'b0;
            cpl_q <= '0; rpl_q <= '0; dpl_q <= '0; gsel_q <= '0; tsel_q <= '0;
            vec_q <= '0; err_q <= '0;
        end else begin
            if (state == ST_IDLE && accept) begin
                k_q <= req_kind_t'(kind); via_q <= via_gate;
                pres_q <= present; busy_q <= desc_busy;
                cpl_q <= cpl; rpl_q <= rpl; dpl_q <= dpl;
                gsel_q <= gate_sel; tsel_q <= tss_sel;
            end
            if (state == ST_CHECK && chk_bad) begin
                vec_q <= chk_vec; err_q <= chk_err;
            end else if ((state == ST_LOAD_LDT || state == ST_LOAD_SEG) && bad_ack) begin
                vec_q <= VEC_W'(VEC_BAD_TSS); err_q <= tsel_q;
            end else if (state == ST_LOAD_IP && bad_ack) begin
                vec_q <= VEC_W'(VEC_PROT); err_q <= '0;
            end
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (accept) nxt = ST_CHECK;
            ST_CHECK:     nxt = chk_bad ? ST_FAULT : (nested ? ST_SET_BUSY : ST_CLR_OLD);
            ST_CLR_OLD:   if (mem_ack) nxt = ST_SET_BUSY;
            ST_SET_BUSY:  if (mem_ack) nxt = ST_SAVE_OLD;
            ST_SAVE_OLD:  if (mem_ack) nxt = ST_LOAD_REGS;
            ST_LOAD_REGS: if (mem_ack) nxt = ST_FLAGS;
            ST_FLAGS:     nxt = ST_LOAD_LDT;
            ST_LOAD_LDT:  if (mem_ack) nxt = mem_bad ? ST_FAULT : ST_LOAD_SEG;
            ST_LOAD_SEG:  if (mem_ack) nxt = mem_bad ? ST_FAULT : ST_LOAD_IP;
            ST_LOAD_IP:   if (mem_ack) nxt = mem_bad ? ST_FAULT : ST_DONE;
            ST_DONE:      nxt = ST_IDLE;
            ST_FAULT:     nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        active    = (state != ST_IDLE);
        set_ts    = (state == ST_FLAGS);
        set_nt    = (state == ST_FLAGS) && nested;
        done      = (state == ST_DONE);
        fault     = (state == ST_FAULT);
        fault_vec = fault ? vec_q : '0;
        fault_err = fault ? err_q : '0;
    end

    // Assertions
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req && !done && !fault);

    p_iret_plain_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start && kind == 2'd3 && !nt_flag) |=> !active);

    p_nt_needs_ts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_nt |-> set_ts);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op)));

    p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_vec == VEC_W'(VEC_BAD_TSS) || fault_vec == VEC_W'(VEC_NOT_PRES)
                   || fault_vec == VEC_W'(VEC_PROT)));

    p_done_after_ip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_ack && !mem_bad && mem_op == OP_W'(OP_LOAD_IP)));

    p_excl_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/task_switch_seq_test.sv
`timescale 1ns/1ps
module task_switch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic        via_gate = 1'b0;
    logic [1:0]  cpl = 2'd0, rpl = 2'd0, dpl = 2'd0;
    logic        present = 1'b1, desc_busy = 1'b0, nt_flag = 1'b0;
    logic [15:0] gate_sel = 16'h0, tss_sel = 16'h0;
    logic        mem_ack = 1'b0, mem_bad = 1'b0;
    logic        active, mem_req, set_ts, set_nt, done, fault;
    logic [3:0]  mem_op;
    logic [7:0]  fault_vec;
    logic [15:0] fault_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    task_switch_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .via_gate(via_gate),
        .cpl(cpl), .rpl(rpl), .dpl(dpl), .present(present), .desc_busy(desc_busy),
        .nt_flag(nt_flag), .gate_sel(gate_sel), .tss_sel(tss_sel),
        .mem_ack(mem_ack), .mem_bad(mem_bad), .active(active), .mem_req(mem_req),
        .mem_op(mem_op), .set_ts(set_ts), .set_nt(set_nt), .done(done), .fault(fault),
        .fault_vec(fault_vec), .fault_err(fault_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_vec(input int k, input bit vg, input int c, input int r,
                                   input int d, input bit p, input bit b, input int badop);
        if (k != 3 && (d < c || d < r)) return 13;
        if (!p) return 11;
        if (b) return 13;
        if (badop == 5 || badop == 6) return 10;
        if (badop == 7) return 13;
        return 0;
    endfunction

    function automatic int exp_err(input int k, input bit vg, input int c, input int r,
                                   input int d, input bit p, input bit b, input int badop,
                                   input int gs, input int ts);
        if (k != 3 && (d < c || d < r)) return vg ? gs : ts;
        if (!p || b) return ts;
        if (badop == 5 || badop == 6) return ts;
        return 0;
    endfunction

    function automatic int exp_ops(input int k, input int badop, input bit entry_bad);
        int w = 0;
        int last = (badop >= 5) ? badop : 7;
        if (entry_bad) return 0;
        for (int op = (k == 1 || k == 2) ? 2 : 1; op <= last; op++) w = (w << 4) | op;
        return w;
    endfunction

    task automatic run_sw(input int k, input bit vg, input int c, input int r, input int d,
                          input bit p, input bit b, input int badop, input bit extra);
        int  ops = 0;
        int  n = 0;
        int  wait_c = 0;
        bit  saw_done = 0, saw_fault = 0, saw_ts = 0, saw_nt = 0, ended = 0;
        int  got_vec = 0, got_err = 0;
        int  gs = $urandom & 16'hffff;
        int  ts = $urandom & 16'hffff;
        int  ev, ee, eo;
        bit  entry_bad;
        @(negedge clk);
        kind = 2'(k); via_gate = vg; cpl = 2'(c); rpl = 2'(r); dpl = 2'(d);
        present = p; desc_busy = b; nt_flag = 1'b1;
        gate_sel = 16'(gs); tss_sel = 16'(ts); start = 1'b1;
        for (int cyc = 0; cyc < 300 && !ended; cyc++) begin
            @(negedge clk);
            start = 1'b0; mem_ack = 1'b0; mem_bad = 1'b0;
            if (extra && n == 2) start = 1'b1;  // R9: start while active must be ignored
            if (set_ts) saw_ts = 1;
            if (set_nt) saw_nt = 1;
            if (fault) begin
                saw_fault = 1; got_vec = fault_vec; got_err = fault_err; ended = 1;
            end else if (done) begin
                saw_done = 1; ended = 1;
            end else if (mem_req) begin
                if (wait_c == 0) begin
                    ops = (ops << 4) | int'(mem_op); n++;
                    mem_ack = 1'b1; mem_bad = (int'(mem_op) == badop);
                    wait_c = $urandom % 4;
                end else wait_c--;
            end
        end
        start = 1'b0; mem_ack = 1'b0; mem_bad = 1'b0;
        if (!ended) chk(0, "R7 watchdog: switch never finished", 0, 1);
        entry_bad = (k != 3 && (d < c || d < r)) || !p || b;
        ev = exp_vec(k, vg, c, r, d, p, b, badop);
        ee = exp_err(k, vg, c, r, d, p, b, badop, gs, ts);
        eo = exp_ops(k, badop, entry_bad);
        chk(ops == eo, "R5/R8 phase sequence", ops, eo);
        if (ev == 0) begin
            chk(saw_done && !saw_fault, "R9 done on success", saw_done, 1);
        end else begin
            chk(saw_fault && !saw_done, "R2/R4/R8 fault raised", saw_fault, 1);
            chk(got_vec == ev, "R2/R4/R8 fault vector", got_vec, ev);
            chk(got_err == ee, "R2/R4/R8 error selector", got_err, ee);
        end
        chk(saw_ts == !entry_bad, "R6 task-switched pulse", saw_ts, !entry_bad);
        chk(saw_nt == (!entry_bad && (k == 1 || k == 2)), "R6 nested flag pulse",
            saw_nt, (!entry_bad && (k == 1 || k == 2)));
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0286));
        repeat (3) @(negedge clk);
        chk(!active && !mem_req && !done && !fault && !set_ts && !set_nt,
            "R1 reset state", {active, mem_req, done, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!active && !mem_req, "R1 idle after reset", {active, mem_req}, 0);

        // R3: interrupt-return with clear nested flag is ignored
        kind = 2'd3; nt_flag = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            bit quiet = 1;
            for (int i = 0; i < 8; i++) begin
                if (active || mem_req || done || fault) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, "R3 plain interrupt-return ignored", !quiet, 0);
        end

        // Directed corners
        run_sw(0, 0, 0, 0, 0, 1, 0, 0, 0);   // R5 jump full path
        run_sw(1, 0, 1, 1, 2, 1, 0, 0, 0);   // R5 call nested path
        run_sw(2, 1, 3, 0, 1, 1, 0, 0, 0);   // R2 gate privilege fault
        run_sw(1, 0, 0, 3, 2, 1, 0, 0, 0);   // R2 requester privilege fault, tss sel
        run_sw(3, 0, 3, 3, 0, 1, 0, 0, 0);   // R3 iret skips privilege
        run_sw(0, 0, 0, 0, 3, 0, 1, 0, 0);   // R4 not present beats busy
        run_sw(2, 0, 0, 0, 3, 1, 1, 0, 0);   // R4 busy
        run_sw(1, 1, 3, 3, 2, 0, 0, 0, 0);   // R4 privilege beats present
        run_sw(0, 0, 0, 0, 0, 1, 0, 5, 0);   // R8 local table fault
        run_sw(1, 0, 0, 0, 0, 1, 0, 6, 0);   // R8 segment fault
        run_sw(3, 0, 0, 0, 0, 1, 0, 7, 0);   // R8 instruction pointer fault
        run_sw(2, 0, 0, 0, 0, 1, 0, 0, 1);   // R9 start during switch ignored

        // Constrained random
        for (int t = 0; t < 60; t++) begin
            int sel = $urandom % 8;
            int bop = (sel < 5) ? 0 : sel;
            run_sw($urandom % 4, $urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4,
                   ($urandom % 10) != 0, ($urandom % 10) == 0, bop, ($urandom % 4) == 0);
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule